// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps, for each line in a small table of directory entries, a record of which nodes hold a copy. In the common case an entry stores up to a fixed number of exact node identifiers, each with its own valid flag. When one sharer too many arrives, one of two policies applies. The entry can fall back to a coarse vector, where each bit stands for a group of neighbouring nodes. Alternatively, it can make room by displacing one recorded sharer, which is reported so that an invalidation can be sent to it.

Each request names one entry and one node and performs a single operation: add a sharer, remove a sharer, query the current sharer set, or process a write. A write returns the mask of nodes that must be invalidated, leaving out the writer itself. The entry is then left holding only the writer. In coarse mode the returned set can be a superset of the true sharers, because whole groups are marked. Responses appear one clock after the request.

Top module: `dlp_dir_mgr`

## Requirements
- R1: After reset every entry is empty: a query of any entry returns an all-zero mask, and rsp_valid and evict_valid are low.
- R2: In pointer mode, up to PTRS distinct sharers are held exactly. A query returns a mask with bit n set exactly for each recorded node n.
- R3: Adding a node that is already a recorded sharer changes nothing, so it does not take a second pointer slot.
- R4: In pointer mode, a remove clears the pointer matching the node. A remove of a node that is not recorded has no effect.
- R5: With req_evict_mode low, adding a new node to a full pointer entry switches the entry to coarse mode. Group g (nodes g*CLUSTER to g*CLUSTER+CLUSTER-1) is then marked for the group of every recorded sharer and for the new node's group. A query returns every node of each marked group.
- R6: In coarse mode, removes are ignored, and adds mark the group of the added node.
- R7: A write op returns, on rsp_mask, the current sharer set with the writer's own bit cleared. The entry then holds only the writer, in pointer mode.
- R8: With req_evict_mode high, adding a new node to a full pointer entry raises evict_valid and drives evict_node with the identity of the displaced sharer. The new node takes that sharer's slot. Victim slots are chosen in round-robin order starting at slot 0 after reset or a write.
- R9: rsp_valid is high exactly in the cycle after a query or write request. evict_valid is high only in the cycle after an add that displaces a sharer. Op encoding: add=0, remove=1, query=2, write=3.
- R10: Operations on one entry leave every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 0 add, 1 remove, 2 query, 3 write |
| req_entry | input | $clog2(ENTRIES) | Entry index |
| req_node | input | $clog2(NODES) | Node being added, removed or writing |
| req_evict_mode | input | 1 | Overflow policy: 1 displaces a sharer, 0 goes coarse |
| rsp_valid | output | 1 | Sharer/invalidation mask valid |
| rsp_mask | output | NODES | One bit per node |
| evict_valid | output | 1 | A sharer was displaced |
| evict_node | output | $clog2(NODES) | Identity of the displaced sharer |

## Verification
The bench uses the default parameters: 16 nodes, two pointers per entry, groups of four nodes and four entries. With only two pointers, the third distinct sharer already forces overflow, so both the coarse fallback and the round-robin displacement are reached within a few requests. The 16-node, 4-group split makes superset masks such as whole groups easy to predict. Having four entries lets the bench show that work on one entry leaves the others untouched.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_REMOVE = 2'd1,
        OP_QUERY  = 2'd2,
        OP_WRITE  = 2'd3
    } dir_op_e;
endpackage

// File: rtl/dlp_slot_scan.sv
// Compares a node id against every pointer slot; reports match and first free slot.
module dlp_slot_scan #(
    parameter int NODES = 16,
    parameter int PTRS  = 2
) (
    input  logic [PTRS-1:0]                   vld,
    input  logic [PTRS*$clog2(NODES)-1:0]     ptr_flat,
    input  logic [$clog2(NODES)-1:0]          node,
    output logic                              hit,
    output logic [PTRS-1:0]                   hit_vec,
    output logic                              free_any,
    output logic [(PTRS>1?$clog2(PTRS):1)-1:0] free_idx
);
    localparam int NODE_W = $clog2(NODES);
    localparam int VIC_W  = (PTRS > 1) ? $clog2(PTRS) : 1;

    for (genvar i = 0; i < PTRS; i++) begin : g_cmp
        assign hit_vec[i] = vld[i] && (ptr_flat[i*NODE_W +: NODE_W] == node);
    end

    assign hit      = |hit_vec;
    assign free_any = ~&vld;

    always_comb begin
        free_idx = '0;
        for (int i = PTRS - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = VIC_W'(i);
        end
    end
endmodule

// File: rtl/dlp_set_expand.sv
// Expands an entry's sharer record into one bit per node.
module dlp_set_expand #(
    parameter int NODES   = 16,
    parameter int PTRS    = 2,
    parameter int CLUSTER = 4
) (
    input  logic                          coarse,
    input  logic [PTRS-1:0]               vld,
    input  logic [PTRS*$clog2(NODES)-1:0] ptr_flat,
    input  logic [NODES/CLUSTER-1:0]      grp,
    output logic [NODES-1:0]              mask
);
    localparam int NODE_W = $clog2(NODES);

    for (genvar n = 0; n < NODES; n++) begin : g_node
        logic [PTRS-1:0] m;
        for (genvar i = 0; i < PTRS; i++) begin : g_ptr
            assign m[i] = vld[i] && (ptr_flat[i*NODE_W +: NODE_W] == NODE_W'(n));
        end
        assign mask[n] = coarse ? grp[n / CLUSTER] : |m;
    end
endmodule

// File: rtl/dlp_dir_mgr.sv
module dlp_dir_mgr
    import dlp_pkg::*;
#(
    parameter int NODES   = 16,
    parameter int PTRS    = 2,
    parameter int CLUSTER = 4,
    parameter int ENTRIES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [1:0]                   req_op,
    input  logic [$clog2(ENTRIES)-1:0]   req_entry,
    input  logic [$clog2(NODES)-1:0]     req_node,
    input  logic                         req_evict_mode,
    output logic                         rsp_valid,
    output logic [NODES-1:0]             rsp_mask,
    output logic                         evict_valid,
    output logic [$clog2(NODES)-1:0]     evict_node
);
    localparam int NODE_W = $clog2(NODES);
    localparam int GROUPS = NODES / CLUSTER;
    localparam int VIC_W  = (PTRS > 1) ? $clog2(PTRS) : 1;

    typedef struct packed {
        logic                         coarse;
        logic [PTRS-1:0]              vld;
        logic [PTRS-1:0][NODE_W-1:0]  ptr;
        logic [GROUPS-1:0]            grp;
        logic [VIC_W-1:0]             victim;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0]  tab;
        logic                  rsp_valid;
        logic [NODES-1:0]      rsp_mask;
        logic                  evict_valid;
        logic [NODE_W-1:0]     evict_node;
    } state_t;

    state_t state_d, state_q;
    entry_t cur;

    logic              hit, free_any;
    logic [PTRS-1:0]   hit_vec;
    logic [VIC_W-1:0]  free_idx;
    logic [NODES-1:0]  cur_mask;

    assign cur = state_q.tab[req_entry];

    dlp_slot_scan #(.NODES(NODES), .PTRS(PTRS)) u_scan (
        .vld      (cur.vld),
        .ptr_flat (cur.ptr),
        .node     (req_node),
        .hit      (hit),
        .hit_vec  (hit_vec),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    dlp_set_expand #(.NODES(NODES), .PTRS(PTRS), .CLUSTER(CLUSTER)) u_expand (
        .coarse   (cur.coarse),
        .vld      (cur.vld),
        .ptr_flat (cur.ptr),
        .grp      (cur.grp),
        .mask     (cur_mask)
    );

    always_comb begin
        entry_t            nxt;
        logic [GROUPS-1:0] fold;
        state_d             = state_q;
        state_d.rsp_valid   = 1'b0;
        state_d.rsp_mask    = '0;
        state_d.evict_valid = 1'b0;
        state_d.evict_node  = '0;
        nxt  = cur;
        fold = '0;
        fold[int'(req_node) / CLUSTER] = 1'b1;
        for (int i = 0; i < PTRS; i++) begin
            if (cur.vld[i]) fold[int'(cur.ptr[i]) / CLUSTER] = 1'b1;
        end

        if (req_valid) begin
            case (dir_op_e'(req_op))
                OP_ADD: begin
                    if (cur.coarse) begin
                        nxt.grp[int'(req_node) / CLUSTER] = 1'b1;
                    end else if (hit) begin
                        nxt = cur;
                    end else if (free_any) begin
                        nxt.vld[free_idx] = 1'b1;
                        nxt.ptr[free_idx] = req_node;
                    end else if (req_evict_mode) begin
                        state_d.evict_valid = 1'b1;
                        state_d.evict_node  = cur.ptr[cur.victim];
                        nxt.ptr[cur.victim] = req_node;
                        nxt.victim = (cur.victim == VIC_W'(PTRS - 1)) ? '0 : cur.victim + 1'b1;
                    end else begin
                        nxt.coarse = 1'b1;
                        nxt.vld    = '0;
                        nxt.grp    = fold;
                    end
                end
                OP_REMOVE: begin
                    if (!cur.coarse) nxt.vld = cur.vld & ~hit_vec;
                end
                OP_QUERY: begin
                    state_d.rsp_valid = 1'b1;
                    state_d.rsp_mask  = cur_mask;
                end
                default: begin
                    state_d.rsp_valid = 1'b1;
                    state_d.rsp_mask  = cur_mask & ~(NODES'(1) << req_node);
                    nxt        = '0;
                    nxt.vld[0] = 1'b1;
                    nxt.ptr[0] = req_node;
                end
            endcase
            state_d.tab[req_entry] = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign rsp_valid   = state_q.rsp_valid;
    assign rsp_mask    = state_q.rsp_mask;
    assign evict_valid = state_q.evict_valid;
    assign evict_node  = state_q.evict_node;
endmodule

// File: rtl/dlp_dir_mgr_chk.sv
module dlp_dir_mgr_chk #(
    parameter int NODES   = 16,
    parameter int ENTRIES = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic [1:0]                 req_op,
    input logic [$clog2(NODES)-1:0]   req_node,
    input logic                       req_evict_mode,
    input logic                       rsp_valid,
    input logic [NODES-1:0]           rsp_mask,
    input logic                       evict_valid,
    input logic [$clog2(NODES)-1:0]   evict_node
);
    // R9: a response only follows a query or write
    p_rsp_after_read_or_write_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_op[1]));

    // R9: query or write always answered next cycle
    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op[1]) |=> rsp_valid);

    // R8: displacement only on an add under the displacing policy
    p_evict_only_on_add_r8: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> $past(req_valid && req_op == 2'd0 && req_evict_mode));

    // R8: the displaced sharer is never the node being added
    p_evict_not_new_r8: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> evict_node != $past(req_node));

    // R7: writer never invalidates itself
    p_writer_excluded_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_op) == 2'd3) |-> !rsp_mask[$past(req_node)]);

    // R9: response and displacement never share a cycle
    p_rsp_evict_apart_r9: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && evict_valid));
endmodule

bind dlp_dir_mgr dlp_dir_mgr_chk #(.NODES(NODES), .ENTRIES(ENTRIES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .req_node       (req_node),
    .req_evict_mode (req_evict_mode),
    .rsp_valid      (rsp_valid),
    .rsp_mask       (rsp_mask),
    .evict_valid    (evict_valid),
    .evict_node     (evict_node)
);

// File: tb/dlp_dir_mgr_test.sv
module dlp_dir_mgr_test;
    localparam int NODES = 16, PTRS = 2, CLUSTER = 4, ENTRIES = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_entry = 2'd0;
    logic [3:0]  req_node = 4'd0;
    logic        req_evict_mode = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_mask;
    logic        evict_valid;
    logic [3:0]  evict_node;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dlp_dir_mgr #(.NODES(NODES), .PTRS(PTRS), .CLUSTER(CLUSTER), .ENTRIES(ENTRIES)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_entry(req_entry), .req_node(req_node), .req_evict_mode(req_evict_mode),
        .rsp_valid(rsp_valid), .rsp_mask(rsp_mask),
        .evict_valid(evict_valid), .evict_node(evict_node)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, leave outputs of the following rising edge to sample
    task automatic op(input logic [1:0] o, input int ent, input int node, input bit ev);
        req_valid = 1'b1; req_op = o; req_entry = 2'(ent);
        req_node = 4'(node); req_evict_mode = ev;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic query_chk(input string req, input int ent, input logic [15:0] exp);
        op(2'd2, ent, 0, 1'b0);
        chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({req, " mask"}, 32'(rsp_mask), 32'(exp));
    endtask

    function automatic logic [15:0] grp_bits(input int node);
        return 16'hF << ((node / CLUSTER) * CLUSTER);
    endfunction

    task automatic t_reset;
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 evict_valid", 32'(evict_valid), 32'd0);
        for (int e = 0; e < ENTRIES; e++) query_chk("R1 empty", e, 16'h0);
    endtask

    task automatic t_exact;
        op(2'd0, 0, 3, 1'b0);
        chk("R9 no rsp after add", 32'(rsp_valid), 32'd0);
        op(2'd0, 0, 3, 1'b0);   // duplicate
        op(2'd0, 0, 9, 1'b0);   // would overflow if duplicate had taken a slot
        query_chk("R2 R3 exact", 0, 16'h0208);
    endtask

    task automatic t_remove;
        op(2'd1, 0, 5, 1'b0);
        query_chk("R4 remove absent", 0, 16'h0208);
        op(2'd1, 0, 3, 1'b0);
        query_chk("R4 remove present", 0, 16'h0200);
    endtask

    task automatic t_coarse;
        logic [15:0] e;
        e = grp_bits(1) | grp_bits(6) | grp_bits(13);
        op(2'd0, 1, 1, 1'b0);
        op(2'd0, 1, 6, 1'b0);
        op(2'd0, 1, 13, 1'b0);
        chk("R5 no evict", 32'(evict_valid), 32'd0);
        query_chk("R5 coarse", 1, e);
        op(2'd1, 1, 6, 1'b0);
        query_chk("R6 remove ignored", 1, e);
        op(2'd0, 1, 9, 1'b0);
        e = e | grp_bits(9);
        query_chk("R6 coarse add", 1, e);
    endtask

    task automatic t_write;
        op(2'd3, 1, 2, 1'b0);
        chk("R7 write valid", 32'(rsp_valid), 32'd1);
        chk("R7 write mask", 32'(rsp_mask), 32'(16'hFFFB));
        query_chk("R7 writer only", 1, 16'h0004);
    endtask

    task automatic t_evict;
        op(2'd0, 2, 4, 1'b1);
        op(2'd0, 2, 7, 1'b1);
        chk("R8 no evict when free", 32'(evict_valid), 32'd0);
        op(2'd0, 2, 11, 1'b1);
        chk("R8 evict pulse", 32'(evict_valid), 32'd1);
        chk("R8 victim slot0", 32'(evict_node), 32'd4);
        query_chk("R8 replaced", 2, 16'h0880);
        chk("R9 evict one cycle", 32'(evict_valid), 32'd0);
        op(2'd0, 2, 12, 1'b1);
        chk("R8 victim slot1", 32'(evict_node), 32'd7);
        query_chk("R8 replaced again", 2, 16'h1800);
        op(2'd3, 2, 11, 1'b1);
        chk("R7 write excl writer", 32'(rsp_mask), 32'(16'h1000));
        op(2'd0, 2, 0, 1'b1);
        op(2'd0, 2, 1, 1'b1);
        chk("R8 round robin restarts", 32'(evict_node), 32'd11);
    endtask

    task automatic t_isolation;
        query_chk("R10 entry0 kept", 0, 16'h0200);
        query_chk("R10 entry3 empty", 3, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_exact;
        t_remove;
        t_coarse;
        t_write;
        t_evict;
        t_isolation;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule